// File: doc/BRIEF.md
# Multi-Pair Correlated Sampling Hit Extractor

This block sits behind the digitisers of an integrating front end. Every channel is sampled at a fixed rate, all the time, whether or not a signal is present. The samples of all channels arrive interleaved on one stream, each tagged with its channel number. For every channel the block keeps a short window of that channel's most recent samples. When the window shows a rising edge above a programmable level, the block reports a hit. No trigger or spill input is needed.

For each hit the block forms a pulse height from several correlated pairs placed symmetrically around the edge. Each pair is the difference between a sample after the edge and its mirror sample before it. Each pair has its own signed weight, loaded at run time, so a coefficient set matched to the measured noise can be installed without rebuilding the design. The sum is kept at full precision and then clamped to a signed 16-bit field. The record also carries the channel and the 32-bit time-base value of the first sample after the edge. Records leave on a valid/ready stream through a small FIFO, and a sticky flag reports any record lost because that FIFO was full.

Top module: `mcs_hit_extractor`

## Requirements
- R1: A channel can report a hit only once it has received at least 2*NPAIR samples (8 by default) since reset; until then, no record is produced for it, whatever the sample values.
- R2: Let n[0] be the newest sample of a channel and n[k] the one k samples older. On each sample, a hit is declared when the signed difference n[NPAIR-1] - n[NPAIR] is strictly greater than the unsigned threshold; equality gives no hit.
- R3: The pulse height is the sum over i = 0..NPAIR-1 of weight[i] * (n[NPAIR-1-i] - n[NPAIR+i]), computed at full precision and then clamped to the range -32768..32767.
- R4: Configuration writes (cfg_we_i high) decode cfg_addr_i as follows: 0..NPAIR-1 select the signed 16-bit weights (reset value 0), NPAIR selects the threshold (reset value 0xFFFF), NPAIR+1 selects the holdoff (reset value 0), and other addresses are ignored. A write takes effect for samples accepted on later clock edges.
- R5: After a hit, the next H samples of that channel cannot produce a hit, where H is the holdoff value at the time of the hit. Other channels are not affected.
- R6: The timestamp of a record is the value of ts_i in the cycle when sample n[NPAIR-1] of the triggering window was accepted.
- R7: With an empty FIFO, a record is presented on m_valid_o in the cycle after the clock edge that accepted the triggering sample. While m_ready_i is low, a presented record and m_valid_o stay unchanged. Records leave in the order their hits occurred.
- R8: The FIFO holds DEPTH records. If a hit occurs while the FIFO is full and no record leaves in the same cycle, that hit is dropped and overflow_o is set. overflow_o is cleared only by reset.
- R9: Channels are independent: the window, fill count and holdoff of one channel are unaffected by samples on any other channel, and the record's channel field is the tag of the triggering sample.
- R10: After reset, m_valid_o and overflow_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid_i | input | 1 | A sample is present this cycle |
| s_chan_i | input | 5 | Channel tag of the sample |
| s_data_i | input | 12 | Unsigned sample value |
| ts_i | input | 32 | Global time-base count |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_data_i | input | 16 | Configuration write data |
| m_valid_o | output | 1 | Hit record available |
| m_ready_i | input | 1 | Consumer accepts the record |
| m_chan_o | output | 5 | Channel of the hit |
| m_height_o | output | 16 | Signed, clamped pulse height |
| m_ts_o | output | 32 | Timestamp of the first sample after the edge |
| overflow_o | output | 1 | Sticky flag set when a record was dropped |

## Verification
A record is due one cycle after the rising edge that accepts the sample completing the window. The overflow flag changes on that same edge. A configuration write affects only samples accepted on later edges. The bench's reference model advances on each rising edge from the inputs held steady since the previous falling edge, and the outputs are compared with the model on every falling edge. This way each result is checked exactly one edge after its cause, never on the edge itself. Directed sequences then confirm hand-computed heights, timestamps and hit counts at fixed points once the stream is idle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int PH_W   = 16;  // pulse-height field
  localparam int TS_W   = 32;  // time-base width
  localparam int WGT_W  = 16;  // pair weight / config data width
  localparam int HOLD_W = 16;  // holdoff counter width
endpackage

// File: rtl/mcs_cfg_regs.sv
module mcs_cfg_regs #(
  parameter int NPAIR = 4,
  parameter int WGT_W = 16,
  parameter int HOLD_W = 16,
  localparam int CFG_AW = $clog2(NPAIR + 2)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we_i,
  input  logic [CFG_AW-1:0]        addr_i,
  input  logic [WGT_W-1:0]         data_i,
  output logic signed [WGT_W-1:0]  weight_o [NPAIR],
  output logic [WGT_W-1:0]         thr_o,
  output logic [HOLD_W-1:0]        holdoff_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAIR; i++) weight_o[i] <= '0;
      thr_o     <= '1;
      holdoff_o <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NPAIR; i++)
        if (addr_i == CFG_AW'(i)) weight_o[i] <= data_i;
      if (addr_i == CFG_AW'(NPAIR))     thr_o     <= data_i;
      if (addr_i == CFG_AW'(NPAIR + 1)) holdoff_o <= HOLD_W'(data_i);
    end
  end
endmodule

// File: rtl/mcs_chan_window.sv
module mcs_chan_window #(
  parameter int N_CH = 32,
  parameter int SAMPLE_W = 12,
  parameter int NPAIR = 4,
  parameter int TS_W = 32,
  parameter int WGT_W = 16,
  parameter int PH_W = 16,
  parameter int HOLD_W = 16,
  localparam int CH_W = $clog2(N_CH),
  localparam int WIN = 2 * NPAIR,
  localparam int FW = $clog2(WIN + 1),
  localparam int DIFF_W = SAMPLE_W + 1,
  localparam int ACC_W = DIFF_W + WGT_W + $clog2(NPAIR) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s_valid_i,
  input  logic [CH_W-1:0]          s_chan_i,
  input  logic [SAMPLE_W-1:0]      s_data_i,
  input  logic [TS_W-1:0]          ts_i,
  input  logic signed [WGT_W-1:0]  weight_i [NPAIR],
  input  logic [WGT_W-1:0]         thr_i,
  input  logic [HOLD_W-1:0]        holdoff_i,
  output logic                     hit_o,
  output logic [CH_W-1:0]          hit_chan_o,
  output logic signed [PH_W-1:0]   hit_height_o,
  output logic [TS_W-1:0]          hit_ts_o
);
  localparam logic signed [ACC_W-1:0] PH_MAX = ACC_W'(2 ** (PH_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] PH_MIN = -PH_MAX - ACC_W'(1);

  // per-channel state; sample/timestamp history needs no reset (fill gates it)
  logic [SAMPLE_W-1:0] win [N_CH][WIN];
  logic [TS_W-1:0]     tsh [N_CH][NPAIR];
  logic [FW-1:0]       fill [N_CH];
  logic [HOLD_W-1:0]   hold [N_CH];

  logic [SAMPLE_W-1:0]      nw  [WIN];
  logic [TS_W-1:0]          nts [NPAIR];
  logic signed [DIFF_W-1:0] diff [NPAIR];
  logic signed [ACC_W-1:0]  acc;
  logic                     full_now, over_thr;

  always_comb begin
    nw[0] = s_data_i;
    for (int k = 1; k < WIN; k++) nw[k] = win[s_chan_i][k-1];
    nts[0] = ts_i;
    for (int k = 1; k < NPAIR; k++) nts[k] = tsh[s_chan_i][k-1];
    acc = '0;
    for (int i = 0; i < NPAIR; i++) begin
      diff[i] = $signed({1'b0, nw[NPAIR-1-i]}) - $signed({1'b0, nw[NPAIR+i]});
      acc = acc + ACC_W'(diff[i]) * ACC_W'(weight_i[i]);
    end
  end

  assign full_now = fill[s_chan_i] >= FW'(WIN - 1);
  assign over_thr = ACC_W'(diff[0]) > $signed(ACC_W'({1'b0, thr_i}));
  assign hit_o    = s_valid_i && full_now && (hold[s_chan_i] == '0) && over_thr;
  assign hit_chan_o = s_chan_i;
  assign hit_ts_o   = nts[NPAIR-1];
  assign hit_height_o = (acc > PH_MAX) ? PH_W'(PH_MAX) :
                        (acc < PH_MIN) ? PH_W'(PH_MIN) : acc[PH_W-1:0];

  always_ff @(posedge clk) begin
    if (s_valid_i) begin
      for (int k = 0; k < WIN; k++)   win[s_chan_i][k] <= nw[k];
      for (int k = 0; k < NPAIR; k++) tsh[s_chan_i][k] <= nts[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < N_CH; c++) begin
        fill[c] <= '0;
        hold[c] <= '0;
      end
    end else if (s_valid_i) begin
      if (fill[s_chan_i] != FW'(WIN)) fill[s_chan_i] <= fill[s_chan_i] + 1'b1;
      if (hit_o)                      hold[s_chan_i] <= holdoff_i;
      else if (hold[s_chan_i] != '0)  hold[s_chan_i] <= hold[s_chan_i] - 1'b1;
    end
  end

  // R5: a hit arms the channel's holdoff with the configured length
  p_holdoff_armed_r5: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> hold[$past(s_chan_i)] == $past(holdoff_i));
endmodule

// File: rtl/mcs_hit_fifo.sv
module mcs_hit_fifo #(
  parameter int DW = 53,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] dout_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop, accept, full;

  assign full    = (count == CW'(DEPTH));
  assign valid_o = (count != '0);
  assign pop     = valid_o && ready_i;
  assign accept  = push_i && (!full || pop);
  assign dout_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)    rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_i && !accept) ovf_o <= 1'b1;
    end
  end

  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  p_ovf_only_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(full));
  p_stall_stable_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ready_i |=> valid_o && $stable(dout_o));
endmodule

// File: rtl/mcs_hit_extractor.sv
module mcs_hit_extractor #(
  parameter int N_CH = 32,
  parameter int SAMPLE_W = 12,
  parameter int NPAIR = 4,
  parameter int DEPTH = 4,
  localparam int CH_W = $clog2(N_CH),
  localparam int CFG_AW = $clog2(NPAIR + 2),
  localparam int PH_W = mcs_pkg::PH_W,
  localparam int TS_W = mcs_pkg::TS_W,
  localparam int WGT_W = mcs_pkg::WGT_W,
  localparam int HOLD_W = mcs_pkg::HOLD_W,
  localparam int REC_W = CH_W + PH_W + TS_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s_valid_i,
  input  logic [CH_W-1:0]        s_chan_i,
  input  logic [SAMPLE_W-1:0]    s_data_i,
  input  logic [TS_W-1:0]        ts_i,
  input  logic                   cfg_we_i,
  input  logic [CFG_AW-1:0]      cfg_addr_i,
  input  logic [WGT_W-1:0]       cfg_data_i,
  output logic                   m_valid_o,
  input  logic                   m_ready_i,
  output logic [CH_W-1:0]        m_chan_o,
  output logic signed [PH_W-1:0] m_height_o,
  output logic [TS_W-1:0]        m_ts_o,
  output logic                   overflow_o
);
  logic signed [WGT_W-1:0] weight [NPAIR];
  logic [WGT_W-1:0]        thr;
  logic [HOLD_W-1:0]       holdoff;
  logic                    hit;
  logic [CH_W-1:0]         hit_chan;
  logic signed [PH_W-1:0]  hit_height;
  logic [TS_W-1:0]         hit_ts;
  logic [REC_W-1:0]        rec_out;

  mcs_cfg_regs #(.NPAIR(NPAIR), .WGT_W(WGT_W), .HOLD_W(HOLD_W)) i_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .weight_o(weight), .thr_o(thr), .holdoff_o(holdoff));

  mcs_chan_window #(.N_CH(N_CH), .SAMPLE_W(SAMPLE_W), .NPAIR(NPAIR), .TS_W(TS_W),
    .WGT_W(WGT_W), .PH_W(PH_W), .HOLD_W(HOLD_W)) i_win (
    .clk(clk), .rst(rst), .s_valid_i(s_valid_i), .s_chan_i(s_chan_i),
    .s_data_i(s_data_i), .ts_i(ts_i), .weight_i(weight), .thr_i(thr),
    .holdoff_i(holdoff), .hit_o(hit), .hit_chan_o(hit_chan),
    .hit_height_o(hit_height), .hit_ts_o(hit_ts));

  mcs_hit_fifo #(.DW(REC_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .push_i(hit), .din_i({hit_chan, hit_height, hit_ts}),
    .valid_o(m_valid_o), .ready_i(m_ready_i), .dout_o(rec_out), .ovf_o(overflow_o));

  assign {m_chan_o, m_height_o, m_ts_o} = rec_out;
endmodule

// File: tb/test_mcs_hit_extractor.sv
module test_mcs_hit_extractor;
  localparam int N_CH = 32, SW = 12, NPAIR = 4, DEPTH = 4, WIN = 2 * NPAIR;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;  // 100 MHz

  logic s_valid = 0, cfg_we = 0, m_ready = 1;
  logic [4:0] s_chan = 0;
  logic [SW-1:0] s_data = 0;
  logic [31:0] ts = 32'h1000_0000;
  logic [2:0] cfg_addr = 0;
  logic [15:0] cfg_data = 0;
  logic m_valid, overflow;
  logic [4:0] m_chan;
  logic signed [15:0] m_height;
  logic [31:0] m_ts;

  mcs_hit_extractor #(.N_CH(N_CH), .SAMPLE_W(SW), .NPAIR(NPAIR), .DEPTH(DEPTH))
    i_mcs_hit_extractor (
    .clk(clk), .rst(rst), .s_valid_i(s_valid), .s_chan_i(s_chan), .s_data_i(s_data),
    .ts_i(ts), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_chan_o(m_chan),
    .m_height_o(m_height), .m_ts_o(m_ts), .overflow_o(overflow));

  always @(negedge clk) ts <= ts + 1;

  int checks = 0, fails = 0;
  bit done = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model (advances on rising edge) ----------------
  int win[N_CH][WIN];
  logic [31:0] tsm[N_CH][NPAIR];
  int fillm[N_CH], holdm[N_CH], wm[NPAIR];
  int thrm, hom;
  int q_ch[$], q_h[$];
  logic [31:0] q_ts[$];
  bit ovfm = 0;

  always @(posedge clk) begin
    bit popm, hitm;
    longint sum;
    int c;
    logic [31:0] tsx;
    if (rst) begin
      for (int i = 0; i < N_CH; i++) begin fillm[i] = 0; holdm[i] = 0; end
      for (int i = 0; i < NPAIR; i++) wm[i] = 0;
      thrm = 65535; hom = 0; ovfm = 0;
      q_ch.delete(); q_h.delete(); q_ts.delete();
    end else begin
      popm = (q_ch.size() > 0) && m_ready;
      hitm = 0; sum = 0; tsx = 0;
      if (s_valid) begin
        c = int'(s_chan);
        for (int k = WIN - 1; k > 0; k--) win[c][k] = win[c][k-1];
        win[c][0] = int'(s_data);
        for (int k = NPAIR - 1; k > 0; k--) tsm[c][k] = tsm[c][k-1];
        tsm[c][0] = ts;
        if (fillm[c] < WIN) fillm[c]++;
        if (holdm[c] > 0) holdm[c]--;
        else if (fillm[c] == WIN && (win[c][NPAIR-1] - win[c][NPAIR]) > thrm) begin
          hitm = 1;
          for (int i = 0; i < NPAIR; i++)
            sum += longint'(wm[i]) * (win[c][NPAIR-1-i] - win[c][NPAIR+i]);
          if (sum > 32767) sum = 32767;
          if (sum < -32768) sum = -32768;
          tsx = tsm[c][NPAIR-1];
          holdm[c] = hom;
        end
      end
      if (popm) begin void'(q_ch.pop_front()); void'(q_h.pop_front()); void'(q_ts.pop_front()); end
      if (hitm) begin
        if (q_ch.size() < DEPTH) begin
          q_ch.push_back(int'(s_chan)); q_h.push_back(int'(sum)); q_ts.push_back(tsx);
        end else ovfm = 1;
      end
      if (cfg_we) begin
        if (cfg_addr < NPAIR) wm[cfg_addr] = int'($signed(cfg_data));
        else if (cfg_addr == NPAIR) thrm = int'(cfg_data);
        else if (cfg_addr == NPAIR + 1) hom = int'(cfg_data);
      end
    end
  end

  // ---------------- per-cycle comparison (falling edge) ----------------
  int obs_cnt = 0, obs_ch = 0, obs_h = 0;
  logic [31:0] obs_ts = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(m_valid == (q_ch.size() > 0), "R7", "m_valid", m_valid, q_ch.size() > 0);
      if (m_valid && q_ch.size() > 0) begin
        chk(int'(m_chan) == q_ch[0], "R9", "channel", m_chan, q_ch[0]);
        chk(int'(m_height) == q_h[0], "R3", "height", m_height, q_h[0]);
        chk(m_ts == q_ts[0], "R6", "timestamp", m_ts, q_ts[0]);
      end
      chk(overflow == ovfm, "R8", "overflow", overflow, ovfm);
      if (m_valid && m_ready) begin
        obs_cnt++; obs_ch = int'(m_chan); obs_h = int'(m_height); obs_ts = m_ts;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(int c, int v);
    @(negedge clk);
    cfg_we = 0; s_valid = 1; s_chan = 5'(c); s_data = SW'(v);
  endtask
  task automatic idle(int n);
    repeat (n) begin @(negedge clk); s_valid = 0; cfg_we = 0; end
  endtask
  task automatic cfg(int a, int d);
    @(negedge clk);
    s_valid = 0; cfg_we = 1; cfg_addr = 3'(a); cfg_data = 16'(d);
  endtask
  task automatic step(int c, int lo, int hi);
    for (int k = 0; k < NPAIR; k++) send(c, lo);
    for (int k = 0; k < NPAIR; k++) send(c, hi);
  endtask

  logic [31:0] t_edge;
  int base;
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    chk(m_valid == 0, "R10", "m_valid after reset", m_valid, 0);
    chk(overflow == 0, "R10", "overflow after reset", overflow, 0);

    // R4: weights 1,2,-1,3; threshold 300; holdoff 0
    cfg(0, 1); cfg(1, 2); cfg(2, 16'hFFFF); cfg(3, 3); cfg(4, 300); cfg(5, 0);
    cfg(7, 5); // unused address, ignored (R4)

    // R1: large step before the window is full
    for (int k = 0; k < NPAIR; k++) send(7, 1000);
    idle(3);
    chk(obs_cnt == 0, "R1", "hits before window full", obs_cnt, 0);

    // R3 / R6: step 100 -> 600 on channel 5
    for (int k = 0; k < NPAIR; k++) send(5, 100);
    send(5, 600); #1 t_edge = ts;
    for (int k = 1; k < NPAIR; k++) send(5, 600);
    idle(3);
    chk(obs_cnt == 1, "R2", "hit count after step", obs_cnt, 1);
    chk(obs_h == 2500, "R3", "weighted height", obs_h, 2500);
    chk(obs_ts == t_edge, "R6", "edge timestamp", obs_ts, t_edge);
    chk(obs_ch == 5, "R9", "record channel", obs_ch, 5);

    // R2: difference equal to threshold, then one above
    step(9, 100, 400); idle(3);
    chk(obs_cnt == 1, "R2", "equal to threshold", obs_cnt, 1);
    step(10, 100, 401); idle(3);
    chk(obs_cnt == 2, "R2", "above threshold", obs_cnt, 2);
    chk(obs_h == 1505, "R3", "height above threshold", obs_h, 1505);

    // R5: holdoff of 10 samples
    cfg(5, 10);
    step(12, 100, 600); idle(2);
    chk(obs_cnt == 3, "R5", "first hit", obs_cnt, 3);
    step(12, 100, 600); idle(2);
    chk(obs_cnt == 3, "R5", "edge inside holdoff", obs_cnt, 3);
    step(12, 100, 600); idle(2);
    chk(obs_cnt == 4, "R5", "edge after holdoff", obs_cnt, 4);

    // R4 / R3: saturation both ways after weight rewrites
    for (int i = 0; i < NPAIR; i++) cfg(i, 16'h7FFF);
    step(13, 0, 4000); idle(3);
    chk(obs_h == 32767, "R4", "positive clamp", obs_h, 32767);
    for (int i = 0; i < NPAIR; i++) cfg(i, 16'h8000);
    step(14, 0, 4000); idle(3);
    chk(obs_h == -32768, "R4", "negative clamp", obs_h, -32768);

    // R8: stalled output, six hits into a four-deep FIFO
    cfg(0, 1); cfg(1, 1); cfg(2, 1); cfg(3, 1); cfg(5, 0);
    base = obs_cnt;
    @(negedge clk); m_ready = 0;
    for (int c = 15; c < 21; c++) step(c, 50, 900);
    idle(3);
    chk(overflow == 1, "R8", "overflow after drop", overflow, 1);
    @(negedge clk); m_ready = 1;
    idle(10);
    chk(obs_cnt - base == DEPTH, "R8", "records kept", obs_cnt - base, DEPTH);
    chk(overflow == 1, "R8", "overflow sticky", overflow, 1);

    // R9 / R7: interleaved channels with a stuttering consumer
    cfg(5, 3);
    for (int r = 0; r < 40; r++)
      for (int c = 0; c < N_CH; c++) begin
        send(c, (r >= 10 + (c % 16)) ? 200 + c * 50 : 100 + (r * 7 + c * 3) % 20);
        m_ready = (c % 3) != 0;
      end
    @(negedge clk); m_ready = 1;
    idle(20);
    chk(!m_valid, "R7", "drained", m_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule